// File: doc/BRIEF.md
# Dual-Granularity SPI Clock Divider

This block turns a fast reference clock into the serial clock of an SPI controller, together with one-cycle strobes that mark each leading and each trailing serial-clock edge, so that a separate shift engine can launch and capture data on them. Nothing is shifted here.

Two division modes are chosen at run time by a granularity bit. In coarse mode a 4-bit code N sets the ratio to 2^N, from 1 up to 32768 reference cycles per serial-clock edge. In fine mode the same 4-bit code becomes the low nibble of a 12-bit value V, with an 8-bit extension field as the high byte, and the ratio is V+1, from 1 to 4096 in steps of one cycle. All divider settings are captured while the block is idle or at the start of a transfer. While a transfer runs, the settings are held and changes to the inputs are ignored. When the run enable drops, the serial clock goes back to its idle level.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is asserted, `sclk`, `lead_stb` and `trail_stb` are low. From the first clock edge after release with `run` low, `sclk` equals `idle_pol`.
- R2: With `fine_sel`=0 the ratio R is 2^`div_code`. If the first edge that sees `run` high is edge 0, a strobe is visible after edge k exactly when k is a positive multiple of R.
- R3: With `fine_sel`=1 the ratio R is {`div_ext`,`div_code`}+1 (extension in the upper 8 bits, code in the lower 4 bits, so 1 to 4096). The strobe timing follows the same rule as R2.
- R4: A ratio of 1 (code 0 in coarse mode, or V=0 in fine mode) gives a strobe after every edge from edge 1 onward, and `sclk` changes on every cycle.
- R5: The first strobe of a transfer is `lead_stb`. After that, `lead_stb` and `trail_stb` strictly alternate, each lasting one cycle, and the two are never high together.
- R6: `sclk` starts a transfer at the idle level. It inverts on exactly the cycles in which a strobe is visible, so it equals `idle_pol` XOR (number of strobes so far, modulo 2).
- R7: After an edge that samples `run` low, both strobes are low, `sclk` equals `idle_pol`, and the next transfer restarts its timing from R2/R3 edge 0.
- R8: Changes to `fine_sel`, `div_code`, `div_ext` or `idle_pol` while `run` stays high do not affect the running transfer. The new values apply from the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Transfer in progress; low returns the clock to idle |
| fine_sel | input | 1 | 0: power-of-two ratio, 1: one-cycle-step ratio |
| div_code | input | 4 | Exponent in coarse mode, low nibble of divisor in fine mode |
| div_ext | input | 8 | High byte of the divisor in fine mode |
| idle_pol | input | 1 | Serial clock level when no transfer runs |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse on each leading serial-clock edge |
| trail_stb | output | 1 | One-cycle pulse on each trailing serial-clock edge |

## Verification
The hardest behaviour to reach from the ports is a settings change that lands in the middle of a running transfer. The stimulus therefore rewrites every configuration input, including the idle polarity, two cycles into a transfer. It then keeps comparing the output against the timing of the originally sampled ratio, and starts a second transfer with the rewritten values to confirm they apply from that point. The extreme ratios are reached directly: coarse code 15 runs for 65535 cycles, and fine value 4095 runs for three full strobe periods. Ratio 1 is covered from both modes.

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int CODE_W = 4,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fine_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic [EXT_W-1:0]  div_ext,
  input  logic              idle_pol,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb
);
  localparam int COARSE_W = (1 << CODE_W) - 1;
  localparam int FINE_W   = CODE_W + EXT_W;
  localparam int CNT_W    = (COARSE_W > FINE_W) ? COARSE_W : FINE_W;

  logic [CNT_W:0]   pow;
  logic [CNT_W-1:0] coarse_lim, fine_lim, sel_lim;
  logic [CNT_W-1:0] lim_q, cnt;
  logic             busy, nxt_lead;

  assign pow        = (CNT_W+1)'(1) << div_code;
  assign coarse_lim = pow[CNT_W-1:0] - CNT_W'(1);

  always_comb begin
    fine_lim = '0;
    fine_lim[FINE_W-1:0] = {div_ext, div_code};
  end

  assign sel_lim = fine_sel ? fine_lim : coarse_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      lim_q     <= '0;
      nxt_lead  <= 1'b1;
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!run) begin
      busy      <= 1'b0;
      cnt       <= '0;
      lim_q     <= sel_lim;
      nxt_lead  <= 1'b1;
      sclk      <= idle_pol;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!busy) begin
      busy      <= 1'b1;
      cnt       <= '0;
      lim_q     <= sel_lim;
      nxt_lead  <= 1'b1;
      sclk      <= idle_pol;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (cnt == lim_q) begin
      cnt       <= '0;
      sclk      <= ~sclk;
      lead_stb  <= nxt_lead;
      trail_stb <= ~nxt_lead;
      nxt_lead  <= ~nxt_lead;
    end else begin
      cnt       <= cnt + CNT_W'(1);
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end
  end

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_stb, trail_stb}));

  a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(idle_pol)) && !lead_stb && !trail_stb);

  a_r6_edge_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |-> (sclk != $past(sclk)));

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(busy) && !lead_stb && !trail_stb) |-> $stable(sclk));

  a_r4_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run && lim_q == '0) |=> (lead_stb || trail_stb));

  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run) |=> $stable(lim_q));
endmodule

// File: tb/spi_sclk_divider_test.sv
`timescale 1ns/1ps
module spi_sclk_divider_test;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, fine_sel = 1'b0, idle_pol = 1'b1;
  logic [3:0] div_code = 4'd0;
  logic [7:0] div_ext = 8'd0;
  logic sclk, lead_stb, trail_stb;
  int checks = 0, errors = 0;
  bit cur_pol;

  always #4 clk = ~clk;

  spi_sclk_divider uut (
    .clk(clk), .rst_n(rst_n), .run(run), .fine_sel(fine_sel),
    .div_code(div_code), .div_ext(div_ext), .idle_pol(idle_pol),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic xfer(input bit f, input logic [3:0] c, input logic [7:0] e,
                      input bit p, input int ns, input bit pert, input string tag);
    int r, n, bt_a, bt_e, bk_a, bk_e, bs_a, bs_e;
    bit ok_t = 1, ok_k = 1, ok_s = 1, exp_stb, exp_lead, exp_s;
    r = f ? int'({e, c}) + 1 : (1 << c);
    @(negedge clk);
    fine_sel = f; div_code = c; div_ext = e; idle_pol = p; run = 1'b1; cur_pol = p;
    for (int k = 0; k <= ns * r + r - 1; k++) begin
      @(negedge clk);
      n = k / r;
      exp_stb  = (k > 0) && (k % r == 0);
      exp_lead = exp_stb && n[0];
      exp_s    = p ^ n[0];
      if (ok_t && ((lead_stb | trail_stb) != exp_stb)) begin
        ok_t = 0; bt_a = k * 2 + (lead_stb | trail_stb); bt_e = k * 2 + exp_stb;
      end
      if (ok_k && exp_stb && (lead_stb != exp_lead || trail_stb != !exp_lead)) begin
        ok_k = 0; bk_a = {lead_stb, trail_stb}; bk_e = {exp_lead, !exp_lead};
      end
      if (ok_s && sclk != exp_s) begin
        ok_s = 0; bs_a = k * 2 + sclk; bs_e = k * 2 + exp_s;
      end
      if (pert && k == 2) begin
        fine_sel = ~f; div_code = c ^ 4'h5; div_ext = e + 8'd3; idle_pol = ~p; cur_pol = ~p;
      end
    end
    check(ok_t, tag, $sformatf("strobe timing ratio %0d (cycle*2+stb)", r), bt_a, bt_e);
    check(ok_k, "R5", $sformatf("strobe kind ratio %0d {lead,trail}", r), bk_a, bk_e);
    check(ok_s, "R6", $sformatf("sclk level ratio %0d (cycle*2+sclk)", r), bs_a, bs_e);
    run = 1'b0;
    @(negedge clk);
    check(sclk == cur_pol && !lead_stb && !trail_stb, "R7", "idle after stop {sclk,lead,trail}",
          {sclk, lead_stb, trail_stb}, {cur_pol, 2'b00});
  endtask

  initial begin
    #(8.0 * 195000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(!sclk && !lead_stb && !trail_stb, "R1", "reset outputs",
          {sclk, lead_stb, trail_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R1", "idle level after release", sclk, 1);
    idle_pol = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R1", "idle level follows polarity", sclk, 0);

    xfer(0, 4'd0, 8'd0, 0, 6, 0, "R4");
    xfer(1, 4'd0, 8'd0, 1, 6, 0, "R4");
    for (int c = 1; c <= 12; c++) xfer(0, 4'(c), 8'd0, c[0], 3, 0, "R2");
    xfer(0, 4'd15, 8'd0, 1, 1, 0, "R2");
    xfer(1, 4'd1, 8'd0, 0, 3, 0, "R3");
    xfer(1, 4'd2, 8'd0, 1, 3, 0, "R3");
    xfer(1, 4'd15, 8'd0, 0, 3, 0, "R3");
    xfer(1, 4'd0, 8'd1, 1, 3, 0, "R3");
    xfer(1, 4'd8, 8'd15, 0, 3, 0, "R3");
    xfer(1, 4'd8, 8'd62, 1, 3, 0, "R3");
    xfer(1, 4'd15, 8'd255, 0, 3, 0, "R3");
    xfer(0, 4'd2, 8'd0, 0, 4, 1, "R8");
    xfer(1, 4'd7, 8'd3, 1, 3, 0, "R8");
    xfer(1, 4'd9, 8'd1, 1, 3, 1, "R8");
    xfer(0, 4'd12, 8'd4, 0, 3, 0, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule